// File: doc/BRIEF.md
# Crosspoint Route Decoder with Pin-Strapped and Programmed Routing

This block produces the per-output source index and drive enable for a crossbar with four inputs and four outputs. The routing comes from one of two places. When the strap-mode pin is high, a two-bit strap select picks one of four fixed routing patterns, and every output is driven. When the strap-mode pin is low, the routing comes from a programmed active register that holds one three-bit code per output.

The programmed path has two buffers. A configuration port writes one output's code at a time into a staging register. Those writes do not reach the outputs until a synchronous load strobe copies the whole staging register into the active register. Because all four lanes are copied on the same clock edge, they change together. Code 000 and the reserved codes 101, 110 and 111 turn the output off. Codes 001 to 100 select inputs 0 to 3.

A combinational route-source selector with two named states picks the source of the outputs. SRC_STRAP is chosen while the strap-mode pin is high. SRC_PROG is chosen while it is low. The selector has no registered transitions: the state follows the pin in the same cycle, in both directions. The physical line drivers are outside this block.

Top module: `route_xpt_top`

## Requirements
- R1: After reset, both the staging and the active registers hold code 000. In programmed mode, `out_en` is 4'b0000 and `out_src` is all zero until the first load.
- R2: With `strap_mode`=1 and `strap_sel`=2'b00, every output is enabled (`out_en`=4'b1111) and every output selects input 0. `out_src`=8'h00, where output i uses bits [2i+1:2i].
- R3: With `strap_mode`=1 and `strap_sel`=2'b01, every output is enabled and selects input 1 (`out_src`=8'h55).
- R4: With `strap_mode`=1 and `strap_sel`=2'b10, outputs 0 and 1 select input 0 and outputs 2 and 3 select input 2 (`out_src`=8'hA0). All outputs are enabled.
- R5: With `strap_mode`=1 and `strap_sel`=2'b11, output i selects input i (`out_src`=8'hE4). All outputs are enabled.
- R6: With `strap_mode`=0, `strap_sel` has no effect on `out_en` or `out_src`.
- R7: An active code from 3'b001 to 3'b100 enables that output and selects input code-1.
- R8: Active code 3'b000 disables that output, and its `out_src` field reads 2'b00.
- R9: Reserved active codes 3'b101, 3'b110 and 3'b111 behave like 3'b000: the output is disabled and its source field reads 2'b00.
- R10: A staging write (`stg_we`=1 writes `stg_code` into lane `stg_port`) has no effect on the outputs until a load occurs. While `load` stays low, the active register does not change.
- R11: A single-cycle `load` pulse sampled at a clock edge copies all four staged codes into the active register on that edge. The outputs reflect all of them together.
- R12: When `load` and a staging write occur on the same edge, the load copies the staging contents from before that edge. The new write takes effect only at the next load.
- R13: Strap mode never alters the staging or active registers. On return to programmed mode, the outputs show the previously loaded routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_mode | input | 1 | 1 selects the strap routing; 0 selects the programmed routing |
| strap_sel | input | 2 | Fixed routing pattern select, used in strap mode |
| stg_we | input | 1 | Staging write enable |
| stg_port | input | 2 | Output lane addressed by a staging write |
| stg_code | input | 3 | Routing code written into the staging lane |
| load | input | 1 | Synchronous strobe that copies staging into active |
| out_src | output | 8 | Source input index per output, 2 bits each, output 0 in the low bits |
| out_en | output | 4 | Drive enable per output, 1 means driven |

## Verification
A wrong staging or active register stays hidden while strap mode is selected. It also stays hidden until the next load, because staged values are not visible on their own. Once a load occurs in programmed mode, a corrupted code shows up in the same cycle as a wrong source index or a wrong enable on the affected lane. A load that copies on the wrong edge, or copies only part of the register, shows up one cycle after the strobe. The bench therefore loads after every staging pattern and compares the outputs against its model on every clock. This makes a latent state error surface within one cycle of the load that exposes it.

// File: rtl/route_pkg.sv
`timescale 1ns/1ps
package route_pkg;

    localparam int NUM_IN  = 4;
    localparam int NUM_OUT = 4;
    localparam int CODE_W  = 3;
    localparam int SRC_W   = $clog2(NUM_IN);
    localparam int IDX_W   = $clog2(NUM_OUT);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SRC_W-1:0]  src_t;

    typedef struct packed {
        logic en;
        src_t src;
    } lane_t;

    typedef enum logic {
        SRC_STRAP = 1'b0,
        SRC_PROG  = 1'b1
    } route_src_e;

    // Codes 1..NUM_IN select input code-1; zero and all reserved codes turn the lane off.
    function automatic lane_t decode_code(input code_t c);
        lane_t l;
        l.en  = 1'b0;
        l.src = '0;
        if ((c != '0) && (int'(c) <= NUM_IN)) begin
            l.en  = 1'b1;
            l.src = src_t'(c - code_t'(1));
        end
        return l;
    endfunction

endpackage

// File: rtl/route_stage.sv
`timescale 1ns/1ps
module route_stage
    import route_pkg::*;
#(
    parameter int N_LANES = NUM_OUT,
    localparam int PORT_W = (N_LANES > 1) ? $clog2(N_LANES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [PORT_W-1:0]         wr_port,
    input  code_t                     wr_code,
    output code_t [N_LANES-1:0]       stage_q
);

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        logic hit;
        assign hit = wr_en && (wr_port == PORT_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= '0;
            end else if (hit) begin
                stage_q[g] <= wr_code;
            end
        end
    end

endmodule

// File: rtl/route_active.sv
`timescale 1ns/1ps
module route_active
    import route_pkg::*;
#(
    parameter int N_LANES = NUM_OUT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  code_t [N_LANES-1:0]  stage_q,
    output code_t [N_LANES-1:0]  active_q
);

    // All lanes share one strobe so the active set only ever changes as a whole.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (load) begin
            active_q <= stage_q;
        end
    end

endmodule

// File: rtl/route_strap.sv
`timescale 1ns/1ps
module route_strap
    import route_pkg::*;
#(
    parameter int N_LANES = NUM_OUT
) (
    input  logic [1:0]           sel,
    output lane_t [N_LANES-1:0]  lanes
);

    localparam int HALF = N_LANES / 2;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int PAIR_SRC     = (g < HALF) ? 0 : 2;
        localparam int STRAIGHT_SRC = g % NUM_IN;

        always_comb begin
            lanes[g].en = 1'b1;
            unique case (sel)
                2'b00:   lanes[g].src = src_t'(0);
                2'b01:   lanes[g].src = src_t'(1);
                2'b10:   lanes[g].src = src_t'(PAIR_SRC);
                2'b11:   lanes[g].src = src_t'(STRAIGHT_SRC);
                default: lanes[g].src = '0;
            endcase
        end
    end

endmodule

// File: rtl/route_xpt_top.sv
`timescale 1ns/1ps
module route_xpt_top
    import route_pkg::*;
#(
    parameter int N_LANES = NUM_OUT,
    localparam int PORT_W = (N_LANES > 1) ? $clog2(N_LANES) : 1,
    localparam int OSRC_W = N_LANES * SRC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strap_mode,
    input  logic [1:0]          strap_sel,
    input  logic                stg_we,
    input  logic [PORT_W-1:0]   stg_port,
    input  logic [CODE_W-1:0]   stg_code,
    input  logic                load,
    output logic [OSRC_W-1:0]   out_src,
    output logic [N_LANES-1:0]  out_en
);

    code_t [N_LANES-1:0] stage_q;
    code_t [N_LANES-1:0] active_q;
    lane_t [N_LANES-1:0] strap_lanes;
    lane_t [N_LANES-1:0] prog_lanes;
    lane_t [N_LANES-1:0] sel_lanes;
    route_src_e          route_src;

    route_stage #(.N_LANES(N_LANES)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (stg_we),
        .wr_port (stg_port),
        .wr_code (stg_code),
        .stage_q (stage_q)
    );

    route_active #(.N_LANES(N_LANES)) u_active (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .stage_q  (stage_q),
        .active_q (active_q)
    );

    route_strap #(.N_LANES(N_LANES)) u_strap (
        .sel   (strap_sel),
        .lanes (strap_lanes)
    );

    for (genvar g = 0; g < N_LANES; g++) begin : g_dec
        assign prog_lanes[g] = decode_code(active_q[g]);
    end

    always_comb begin
        route_src = strap_mode ? SRC_STRAP : SRC_PROG;
    end

    always_comb begin
        unique case (route_src)
            SRC_STRAP: sel_lanes = strap_lanes;
            SRC_PROG:  sel_lanes = prog_lanes;
            default:   sel_lanes = '0;
        endcase
    end

    for (genvar g = 0; g < N_LANES; g++) begin : g_out
        assign out_en[g]                 = sel_lanes[g].en;
        assign out_src[g*SRC_W +: SRC_W] = sel_lanes[g].src;
    end

endmodule

// File: rtl/route_xpt_checker.sv
`timescale 1ns/1ps
module route_xpt_checker
    import route_pkg::*;
#(
    parameter int N_LANES = NUM_OUT
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       strap_mode,
    input logic [1:0]                 strap_sel,
    input logic                       load,
    input logic [N_LANES*SRC_W-1:0]   out_src,
    input logic [N_LANES-1:0]         out_en
);

    // R1: the first cycle out of reset in programmed mode shows every lane off
    a_r1_reset_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && !strap_mode) |-> (out_en == '0));

    // R2: strap pattern 00 drives every lane from input 0
    a_r2_strap_all_in0: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_mode && strap_sel == 2'b00) |-> (out_en == '1 && out_src == '0));

    // R5: the straight strap pattern maps lane i to input i
    a_r5_straight: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_mode && strap_sel == 2'b11) |-> (out_en == 4'hF && out_src == 8'hE4));

    // R8, R9: a disabled lane always reports source zero
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        a_r8_off_src_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !out_en[g] |-> (out_src[g*SRC_W +: SRC_W] == '0));
    end

    // R10: without a load, programmed outputs hold steady
    a_r10_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !strap_mode) ##1 (!strap_mode) |-> ($stable(out_en) && $stable(out_src)));

endmodule

bind route_xpt_top route_xpt_checker #(.N_LANES(N_LANES)) u_chk (.*);

// File: tb/route_xpt_top_bench.sv
`timescale 1ns/1ps
module route_xpt_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_mode = 1'b0;
    logic [1:0] strap_sel = 2'b00;
    logic       stg_we = 1'b0;
    logic [1:0] stg_port = 2'b00;
    logic [2:0] stg_code = 3'b000;
    logic       load = 1'b0;
    logic [7:0] out_src;
    logic [3:0] out_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    int m_stage[4];
    int m_act[4];

    always #4 clk = ~clk;

    route_xpt_top u_route_xpt_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_mode (strap_mode),
        .strap_sel  (strap_sel),
        .stg_we     (stg_we),
        .stg_port   (stg_port),
        .stg_code   (stg_code),
        .load       (load),
        .out_src    (out_src),
        .out_en     (out_en)
    );

    // Behavioural model: load takes the pre-edge staging contents, then the write lands.
    initial for (int i = 0; i < 4; i++) begin m_stage[i] = 0; m_act[i] = 0; end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin m_stage[i] = 0; m_act[i] = 0; end
        end else begin
            if (load) for (int i = 0; i < 4; i++) m_act[i] = m_stage[i];
            if (stg_we) m_stage[stg_port] = int'(stg_code);
        end
    end

    function automatic void model_out(output logic [3:0] en, output logic [7:0] src);
        en = '0; src = '0;
        for (int i = 0; i < 4; i++) begin
            int s;
            bit e;
            if (strap_mode) begin
                e = 1'b1;
                case (strap_sel)
                    2'd0: s = 0;
                    2'd1: s = 1;
                    2'd2: s = (i < 2) ? 0 : 2;
                    default: s = i;
                endcase
            end else if (m_act[i] >= 1 && m_act[i] <= 4) begin
                e = 1'b1; s = m_act[i] - 1;
            end else begin
                e = 1'b0; s = 0;
            end
            en[i] = e;
            src[2*i +: 2] = 2'(s);
        end
    endfunction

    always @(posedge clk) begin
        logic [3:0] e_en;
        logic [7:0] e_src;
        #3;
        if (!done) begin
            model_out(e_en, e_src);
            checks++;
            if (out_en !== e_en || out_src !== e_src) begin
                errors++;
                $display("FAIL %s (model) at %0t: en=%b src=%h expected en=%b src=%h",
                         cur_req, $time, out_en, out_src, e_en, e_src);
            end
        end
    end

    task automatic expect_ports(input string req, input logic [3:0] en, input logic [7:0] src);
        checks++;
        if (out_en !== en || out_src !== src) begin
            errors++;
            $display("FAIL %s at %0t: en=%b src=%h expected en=%b src=%h",
                     req, $time, out_en, out_src, en, src);
        end
    endtask

    task automatic wr(input int p, input int c);
        @(negedge clk);
        stg_we = 1'b1; stg_port = 2'(p); stg_code = 3'(c);
        @(negedge clk);
        stg_we = 1'b0;
    endtask

    task automatic pulse_load();
        @(negedge clk);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic wr_all(input int c0, input int c1, input int c2, input int c3);
        wr(0, c0); wr(1, c1); wr(2, c2); wr(3, c3);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual=hung after %0d cycles, expected=completed", cycles);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1 expect_ports("R1", 4'b0000, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        #1 expect_ports("R1", 4'b0000, 8'h00);

        // R2..R5: strap patterns
        @(negedge clk); strap_mode = 1'b1; strap_sel = 2'b00; cur_req = "R2";
        #1 expect_ports("R2", 4'hF, 8'h00);
        @(negedge clk); strap_sel = 2'b01; cur_req = "R3";
        #1 expect_ports("R3", 4'hF, 8'h55);
        @(negedge clk); strap_sel = 2'b10; cur_req = "R4";
        #1 expect_ports("R4", 4'hF, 8'hA0);
        @(negedge clk); strap_sel = 2'b11; cur_req = "R5";
        #1 expect_ports("R5", 4'hF, 8'hE4);

        // R6: select pins ignored in programmed mode (empty active set)
        cur_req = "R6";
        @(negedge clk); strap_mode = 1'b0;
        for (int s = 0; s < 4; s++) begin
            @(negedge clk); strap_sel = 2'(s);
            #1 expect_ports("R6", 4'b0000, 8'h00);
        end

        // R10: staged writes invisible before load
        cur_req = "R10";
        wr_all(1, 2, 3, 4);
        repeat (2) @(negedge clk);
        #1 expect_ports("R10", 4'b0000, 8'h00);

        // R11: one pulse updates every lane together, then holds
        cur_req = "R11";
        pulse_load();
        #1 expect_ports("R11", 4'hF, 8'hE4);
        repeat (3) @(negedge clk);
        #1 expect_ports("R11", 4'hF, 8'hE4);

        // R6 with a non-empty active set
        cur_req = "R6";
        for (int s = 0; s < 4; s++) begin
            @(negedge clk); strap_sel = 2'(s);
            #1 expect_ports("R6", 4'hF, 8'hE4);
        end

        // R7: every selecting code
        cur_req = "R7";
        for (int c = 1; c <= 4; c++) begin
            wr_all(c, c, c, c);
            pulse_load();
            #1 expect_ports("R7", 4'hF, {4{2'(c - 1)}});
        end
        wr_all(4, 3, 2, 1);
        pulse_load();
        #1 expect_ports("R7", 4'hF, 8'h1B);

        // R8: code zero turns a lane off
        cur_req = "R8";
        wr_all(0, 1, 0, 2);
        pulse_load();
        #1 expect_ports("R8", 4'b1010, 8'h40);

        // R9: reserved codes
        cur_req = "R9";
        for (int c = 5; c <= 7; c++) begin
            wr_all(c, c, c, c);
            pulse_load();
            #1 expect_ports("R9", 4'b0000, 8'h00);
        end
        wr_all(5, 1, 6, 4);
        pulse_load();
        #1 expect_ports("R9", 4'b1010, 8'hC0);

        // R12: load and write on the same edge
        cur_req = "R12";
        @(negedge clk);
        load = 1'b1; stg_we = 1'b1; stg_port = 2'd0; stg_code = 3'd3;
        @(negedge clk);
        load = 1'b0; stg_we = 1'b0;
        #1 expect_ports("R12", 4'b1010, 8'hC0);
        pulse_load();
        #1 expect_ports("R12", 4'b1011, 8'hC2);

        // R13: strap mode leaves programmed state intact
        cur_req = "R13";
        @(negedge clk); strap_mode = 1'b1; strap_sel = 2'b00;
        wr(1, 7);
        #1 expect_ports("R13", 4'hF, 8'h00);
        @(negedge clk); strap_mode = 1'b0;
        #1 expect_ports("R13", 4'b1011, 8'hC2);
        pulse_load();
        #1 expect_ports("R13", 4'b1001, 8'hC2);

        repeat (2) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule